// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block turns single-clock write strobes, each carrying a latched address and data word, into device instructions for a word-programmable non-volatile array. Every instruction must be preceded by a two-write unlock key. The instructions are: return to array read, enter signature read, program one word, and erase the whole chip. Chip erase also needs a second unlock key and a confirm byte. Any write that breaks the expected sequence drops the decoder back to its idle step and selects array read.

The block drives a read-mode selector for the read path: array, signature or status. It gives a one-cycle program-start pulse together with the target address and word, and a one-cycle erase-start pulse. It also supplies the 16-bit signature word for the two low read-address bits. An external busy flag stalls command intake while the array engine runs. When that engine also reports a failure, only the read/reset byte gets through.

Top module: `cmd_seq_ctrl`

## Requirements
- R1: After a synchronous reset the read mode is array (code 0), and both start pulses are low.
- R2: The unlock key is low byte AAh written with address bits 10..0 equal to 555h, then low byte 55h with address bits 10..0 equal to 2AAh. Address bits above 10 and data bits above 7 are ignored.
- R3: After the key, a write with address bits 10..0 equal to 555h selects the instruction by its low byte. 90h selects signature mode (code 1). A0h arms program. 80h arms erase. F0h, which is accepted at any address, selects array mode. While an instruction is armed, the read mode does not change.
- R4: The next accepted write after program is armed raises prog_start for exactly one cycle, in the cycle after the strobe. prog_addr and prog_data then carry that write's full address and data, and the read mode becomes status (code 2).
- R5: After erase is armed, three more writes are needed: AAh at 555h, then 55h at 2AAh, then 10h at 555h. The last raises erase_start for one cycle, in the cycle after the strobe, and the read mode becomes status.
- R6: Any other write at any step is an abort. This covers a wrong byte, a wrong address, and command bytes such as 00h and 20h. An abort returns the decoder to idle with array mode and no pulse.
- R7: In idle, a single write of low byte F0h at any address selects array mode.
- R8: While busy is high and op_fail is low, writes are ignored. The read mode, the pulses and the sequence position are all left untouched.
- R9: While busy and op_fail are both high, only a write with low byte F0h is taken, and it selects array mode. All other writes are ignored.
- R10: In signature mode, sig_data is 0020h when rd_addr_lo is 00, 00C1h when it is 01, and 0000h otherwise. In any other mode sig_data is 0000h.
- R11: prog_start and erase_start never stay high for two cycles in a row, and never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| busy | input | 1 | Array operation in progress |
| op_fail | input | 1 | Array operation reported a failure |
| rd_addr_lo | input | 2 | Low read-address bits selecting the signature word |
| read_mode | output | 2 | 0 array, 1 signature, 2 status |
| sig_data | output | DATA_W | Signature word for the current read address |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | ADDR_W | Address to program |
| prog_data | output | DATA_W | Word to program |
| erase_start | output | 1 | One-cycle chip-erase start |

## Verification
Each write strobe is sampled on one rising edge. The read mode and any start pulse it causes are registered on that same edge, so they are due one cycle after the strobe. The bench raises the strobe at a falling edge and checks the outputs at the following falling edge. It checks one more falling edge later to show that the pulse has ended. sig_data follows read_mode and rd_addr_lo combinationally, so it is checked in the same half-cycle in which rd_addr_lo is changed. The command byte is swept over all 256 values.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;

    localparam int unsigned KEY_W = 11;
    localparam int unsigned CODE_W = 8;

    localparam logic [KEY_W-1:0]  KEY_ADDR_A = 11'h555;
    localparam logic [KEY_W-1:0]  KEY_ADDR_B = 11'h2AA;
    localparam logic [CODE_W-1:0] KEY_BYTE_A = 8'hAA;
    localparam logic [CODE_W-1:0] KEY_BYTE_B = 8'h55;
    localparam logic [CODE_W-1:0] OP_RESET   = 8'hF0;
    localparam logic [CODE_W-1:0] OP_SIG     = 8'h90;
    localparam logic [CODE_W-1:0] OP_PROG    = 8'hA0;
    localparam logic [CODE_W-1:0] OP_ERASE   = 8'h80;
    localparam logic [CODE_W-1:0] OP_CONFIRM = 8'h10;
    localparam logic [CODE_W-1:0] SIG_MFR    = 8'h20;
    localparam logic [CODE_W-1:0] SIG_DEV    = 8'hC1;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_SIG    = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_CMD,
        ST_PGM,
        ST_EKEY0,
        ST_EKEY1,
        ST_ECONF
    } seq_st_e;

    typedef enum logic [2:0] {
        WK_OTHER,
        WK_KEY1,
        WK_KEY2,
        WK_RESET,
        WK_SIG,
        WK_PROG,
        WK_ERASE,
        WK_CONF
    } wr_kind_e;

    typedef struct packed {
        seq_st_e  nxt;
        rd_mode_e mode;
        logic     set_mode;
        logic     pgm;
        logic     ers;
    } step_t;

    function automatic wr_kind_e classify(input logic [KEY_W-1:0] a,
                                          input logic [CODE_W-1:0] d);
        wr_kind_e k;
        k = WK_OTHER;
        if (d == OP_RESET)                          k = WK_RESET;
        else if (a == KEY_ADDR_A && d == KEY_BYTE_A) k = WK_KEY1;
        else if (a == KEY_ADDR_B && d == KEY_BYTE_B) k = WK_KEY2;
        else if (a == KEY_ADDR_A && d == OP_SIG)     k = WK_SIG;
        else if (a == KEY_ADDR_A && d == OP_PROG)    k = WK_PROG;
        else if (a == KEY_ADDR_A && d == OP_ERASE)   k = WK_ERASE;
        else if (a == KEY_ADDR_A && d == OP_CONFIRM) k = WK_CONF;
        return k;
    endfunction

    function automatic step_t next_step(input seq_st_e cur, input wr_kind_e k);
        step_t r;
        r.nxt      = ST_IDLE;
        r.mode     = MODE_ARRAY;
        r.set_mode = 1'b1;
        r.pgm      = 1'b0;
        r.ers      = 1'b0;
        case (cur)
            ST_IDLE: if (k == WK_KEY1) begin
                r.nxt = ST_KEY1; r.set_mode = 1'b0;
            end
            ST_KEY1: if (k == WK_KEY2) begin
                r.nxt = ST_CMD; r.set_mode = 1'b0;
            end
            ST_CMD: begin
                if (k == WK_SIG) r.mode = MODE_SIG;
                else if (k == WK_PROG) begin
                    r.nxt = ST_PGM; r.set_mode = 1'b0;
                end else if (k == WK_ERASE) begin
                    r.nxt = ST_EKEY0; r.set_mode = 1'b0;
                end
            end
            ST_PGM: begin
                r.pgm = 1'b1; r.mode = MODE_STATUS;
            end
            ST_EKEY0: if (k == WK_KEY1) begin
                r.nxt = ST_EKEY1; r.set_mode = 1'b0;
            end
            ST_EKEY1: if (k == WK_KEY2) begin
                r.nxt = ST_ECONF; r.set_mode = 1'b0;
            end
            ST_ECONF: if (k == WK_CONF) begin
                r.ers = 1'b1; r.mode = MODE_STATUS;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmdif_classify.sv
module cmdif_classify
    import cmdif_pkg::*;
(
    input  logic [KEY_W-1:0]  key_addr,
    input  logic [CODE_W-1:0] code,
    output wr_kind_e          kind
);
    always_comb kind = classify(key_addr, code);
endmodule

// File: rtl/cmdif_seq.sv
module cmdif_seq
    import cmdif_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     acc,
    input  logic     force_rst,
    input  wr_kind_e kind,
    output logic     pgm_arm,
    output rd_mode_e mode_q,
    output logic     pgm_fire,
    output logic     ers_fire
);
    seq_st_e st_q;
    step_t   step_c;

    always_comb step_c = next_step(st_q, kind);
    assign pgm_arm = (st_q == ST_PGM);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mode_q   <= MODE_ARRAY;
            pgm_fire <= 1'b0;
            ers_fire <= 1'b0;
        end else begin
            pgm_fire <= 1'b0;
            ers_fire <= 1'b0;
            if (force_rst) begin
                st_q   <= ST_IDLE;
                mode_q <= MODE_ARRAY;
            end else if (acc) begin
                st_q <= step_c.nxt;
                if (step_c.set_mode) mode_q <= step_c.mode;
                pgm_fire <= step_c.pgm;
                ers_fire <= step_c.ers;
            end
        end
    end
endmodule

// File: rtl/cmdif_sig.sv
module cmdif_sig
    import cmdif_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  rd_mode_e          mode,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] word
);
    localparam int unsigned PAD_W = DATA_W - CODE_W;

    always_comb begin
        word = '0;
        if (mode == MODE_SIG) begin
            case (sel)
                2'b00:   word = {{PAD_W{1'b0}}, SIG_MFR};
                2'b01:   word = {{PAD_W{1'b0}}, SIG_DEV};
                default: word = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
    import cmdif_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              op_fail,
    input  logic [1:0]        rd_addr_lo,
    output logic [1:0]        read_mode,
    output logic [DATA_W-1:0] sig_data,
    output logic              prog_start,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_start
);
    wr_kind_e kind;
    rd_mode_e mode;
    logic     pgm_arm;
    logic     acc_norm;
    logic     acc_force;

    assign acc_norm  = wr_stb & ~busy;
    assign acc_force = wr_stb & busy & op_fail & (wr_data[CODE_W-1:0] == OP_RESET);

    cmdif_classify u_cls (
        .key_addr (wr_addr[KEY_W-1:0]),
        .code     (wr_data[CODE_W-1:0]),
        .kind     (kind)
    );

    cmdif_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc_norm),
        .force_rst (acc_force),
        .kind      (kind),
        .pgm_arm   (pgm_arm),
        .mode_q    (mode),
        .pgm_fire  (prog_start),
        .ers_fire  (erase_start)
    );

    cmdif_sig #(.DATA_W(DATA_W)) u_sig (
        .mode (mode),
        .sel  (rd_addr_lo),
        .word (sig_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_addr <= '0;
            prog_data <= '0;
        end else if (acc_norm && pgm_arm) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
        end
    end

    assign read_mode = mode;
endmodule

// File: rtl/cmdif_chk.sv
module cmdif_chk
    import cmdif_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              op_fail,
    input logic [1:0]        read_mode,
    input logic [DATA_W-1:0] sig_data,
    input logic              prog_start,
    input logic              erase_start
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (read_mode == 2'd0 && !prog_start && !erase_start)); // R1

    AST_PROG_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(wr_stb && !busy)); // R4

    AST_PROG_STATUS: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> read_mode == 2'd2); // R4

    AST_ERASE_STATUS: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (read_mode == 2'd2 && $past(wr_stb && !busy))); // R5

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && busy && !op_fail) |=>
            ($stable(read_mode) && !prog_start && !erase_start)); // R8

    AST_FAIL_OTHER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && busy && op_fail && wr_data[7:0] != 8'hF0) |=>
            ($stable(read_mode) && !prog_start && !erase_start)); // R9

    AST_FAIL_RESET_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && busy && op_fail && wr_data[7:0] == 8'hF0) |=> read_mode == 2'd0); // R9

    AST_SIG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (read_mode != 2'd1) |-> sig_data == '0); // R10

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (prog_start || erase_start) |=> !(prog_start || erase_start)); // R11

    AST_NO_DUAL: assert property (@(posedge clk) disable iff (rst)
        $countones({prog_start, erase_start}) <= 1); // R11
endmodule

bind cmd_seq_ctrl cmdif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .busy        (busy),
    .op_fail     (op_fail),
    .read_mode   (read_mode),
    .sig_data    (sig_data),
    .prog_start  (prog_start),
    .erase_start (erase_start)
);

// File: tb/cmd_seq_ctrl_test.sv
module cmd_seq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        op_fail = 1'b0;
    logic [1:0]  rd_addr_lo = 2'b00;
    logic [1:0]  read_mode;
    logic [15:0] sig_data;
    logic        prog_start;
    logic [15:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_start;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmd_seq_ctrl uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .op_fail(op_fail), .rd_addr_lo(rd_addr_lo), .read_mode(read_mode),
        .sig_data(sig_data), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic enter_sig();
        unlock();
        wr(16'h0555, 16'h0090);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mode", read_mode, 0);
        chk("R1 prog", prog_start, 0);
        chk("R1 erase", erase_start, 0);
        chk("R10 sig in array", sig_data, 0);

        // R3 R6 R4 R5: sweep every command byte, key with dirty upper bits (R2)
        for (int c = 0; c < 256; c++) begin
            logic [1:0] exp_mode;
            enter_sig();
            wr({c[4:0], 11'h555}, {c[7:0], 8'hAA});
            wr({c[7:3], 11'h2AA}, {~c[7:0], 8'h55});
            wr(16'h0555, {8'h00, c[7:0]});
            if (c == 8'h90) exp_mode = 2'd1;
            else if (c == 8'hF0) exp_mode = 2'd0;
            else if (c == 8'hA0 || c == 8'h80) exp_mode = 2'd1;
            else exp_mode = 2'd0;
            chk("R3/R6 mode after command", read_mode, exp_mode);
            chk("R6 no pulse on command", {prog_start, erase_start}, 0);
            if (c == 8'hA0) begin
                wr(16'h1000 + c[15:0], 16'hFFFF - c[15:0]);
                chk("R4 prog_start", prog_start, 1);
                chk("R4 prog_addr", prog_addr, 16'h1000 + c[15:0]);
                chk("R4 prog_data", prog_data, 16'hFFFF - c[15:0]);
                chk("R4 status mode", read_mode, 2);
                @(negedge clk);
                chk("R11 prog one cycle", prog_start, 0);
            end
            if (c == 8'h80) begin
                wr(16'h0555, 16'h00AA);
                wr(16'h02AA, 16'h0055);
                chk("R5 no early erase", erase_start, 0);
                wr(16'h0555, 16'h0010);
                chk("R5 erase_start", erase_start, 1);
                chk("R11 no prog with erase", prog_start, 0);
                chk("R5 status mode", read_mode, 2);
                @(negedge clk);
                chk("R11 erase one cycle", erase_start, 0);
            end
        end

        // R10 signature words over read address bits
        enter_sig();
        for (int i = 0; i < 4; i++) begin
            rd_addr_lo = i[1:0];
            #1;
            chk("R10 sig word", sig_data, (i == 0) ? 16'h0020 : (i == 1) ? 16'h00C1 : 16'h0000);
        end
        // R7 single F0 in idle
        wr(16'h7123, 16'h12F0);
        chk("R7 single reset", read_mode, 0);
        rd_addr_lo = 2'b00;
        #1;
        chk("R10 sig quiet in array", sig_data, 0);

        // R2 negative: wrong key address bits and wrong second address
        enter_sig();
        wr(16'h0554, 16'h00AA);
        chk("R2 bad key addr", read_mode, 0);
        enter_sig();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AB, 16'h0055);
        chk("R2 bad second addr", read_mode, 0);
        enter_sig();
        unlock();
        wr(16'h0556, 16'h0090);
        chk("R6 command at wrong addr", read_mode, 0);

        // R6 erase deviations at each extra step
        for (int k = 0; k < 3; k++) begin
            enter_sig();
            unlock();
            wr(16'h0555, 16'h0080);
            for (int j = 0; j <= k; j++) begin
                logic [15:0] a, d;
                a = (j == 1) ? 16'h02AA : 16'h0555;
                d = (j == 0) ? 16'h00AA : (j == 1) ? 16'h0055 : 16'h0010;
                if (j == k) d = d ^ 16'h0001;
                wr(a, d);
            end
            chk("R6 erase abort mode", read_mode, 0);
            chk("R6 erase abort no pulse", erase_start, 0);
        end

        // R8 busy ignores writes, sequence position kept
        enter_sig();
        busy = 1'b1;
        wr(16'h0000, 16'h00F0);
        chk("R8 busy F0 ignored", read_mode, 1);
        busy = 1'b0;
        wr(16'h0555, 16'h00AA);
        busy = 1'b1;
        wr(16'h0000, 16'h0000);
        busy = 1'b0;
        wr(16'h02AA, 16'h0055);
        wr(16'h0555, 16'h00A0);
        busy = 1'b1;
        wr(16'h0042, 16'h0099);
        chk("R8 busy no program", prog_start, 0);
        chk("R8 mode kept", read_mode, 1);
        busy = 1'b0;
        wr(16'h0043, 16'h0098);
        chk("R8 program after busy", prog_start, 1);
        chk("R8 program addr", prog_addr, 16'h0043);

        // R9 busy with failure: only F0 accepted
        busy = 1'b1;
        wr(16'h0000, 16'h00F0);
        chk("R8 status held while busy", read_mode, 2);
        op_fail = 1'b1;
        wr(16'h0555, 16'h00AA);
        chk("R9 non-reset ignored", read_mode, 2);
        wr(16'h0321, 16'h00F0);
        chk("R9 reset taken on fail", read_mode, 0);
        busy = 1'b0;
        op_fail = 1'b0;

        // R1 reset mid-sequence
        enter_sig();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mode after reset", read_mode, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule